// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Controller

This block lets a synchronous host run a successive-approximation converter that has a parallel data bus. When the host asks for a sample, the controller lowers the chip select and then sends a convert-start pulse that is active low. It watches the converter's busy line, and busy going low marks the end of the conversion. The controller then reads the result in one of two ways: a single 16-bit read, or two 8-bit reads on the upper half of the bus with byte select switching between them. The finished two's-complement word is handed to the host through a valid/ready pair.

Every analog timing rule is a parameter counted in system clock cycles. These rules include the convert-start low and high widths, the read-low width, the gap between reads, and the spacing between byte-select changes. They also include the quiet zone around the convert-start falling edge, during which no read may take place. Reads may start only after a set number of cycles have passed since the convert-start edge, and a convert-start edge may come only after a set number of cycles have passed since the last read ended. A bounded wait guards both edges of busy. If busy does not rise, or does not fall, in time, the controller raises a one-cycle error pulse and returns to idle. While a result waits to be accepted, the controller starts no new conversion.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, convst_n_o, cs_n_o and rd_n_o are 1. byte_sel_o, res_valid_o and err_o are 0, and res_data_o is all zeros.
- R2: A start request in idle with no pending result lowers cs_n_o at least one cycle before convst_n_o falls. convst_n_o then stays low for exactly CONV_LOW_CYC cycles and stays high for at least CONV_HIGH_CYC cycles before the next fall.
- R3: At least QUIET_PRE_CYC cycles pass from the last rising edge of rd_n_o to the next falling edge of convst_n_o.
- R4: rd_n_o goes low only after busy_i has risen and then fallen for the current conversion, and only once at least QUIET_POST_CYC cycles have passed since convst_n_o fell.
- R5: With BYTE_MODE=0 there is exactly one read window per conversion. In that window rd_n_o is low for exactly RD_LOW_CYC cycles and byte_sel_o stays 0, and res_data_o takes all 16 bus bits as sampled in the last low cycle.
- R6: With BYTE_MODE=1 there are two read windows, each RD_LOW_CYC cycles long. In the first, byte_sel_o is 0 and bus bits 15..8 become result bits 15..8. In the second, byte_sel_o is 1 and bus bits 15..8 become result bits 7..0, while bus bits 7..0 are ignored. rd_n_o is high for at least RD_HIGH_CYC cycles between the windows, and successive byte_sel_o changes are at least BYTE_GAP_CYC cycles apart.
- R7: The result is the converter's 16-bit two's-complement code, bit for bit. This holds at the limits 16'h7FFF and 16'h8000, at 16'hFFFF (minus one) and at 16'h0000.
- R8: While res_valid_o is 1 and res_ready_i is 0, res_valid_o and res_data_o hold their values, and start_i causes no convert-start pulse. res_valid_o clears in the cycle after res_ready_i is sampled at 1.
- R9: If busy_i does not rise within TIMEOUT_CYC cycles after the convert-start pulse, err_o pulses high for exactly one cycle, cs_n_o returns to 1 and res_valid_o stays 0.
- R10: If busy_i rises but does not fall within TIMEOUT_CYC cycles, err_o pulses high for one cycle, no read takes place and res_valid_o stays 0. A later conversion then completes normally.
- R11: cs_n_o is 0 whenever convst_n_o or rd_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request for one conversion, sampled in idle |
| res_ready_i | input | 1 | Host accepts the presented result |
| busy_i | input | 1 | Converter busy line, asynchronous |
| bus_i | input | DATA_W | Converter parallel data bus |
| convst_n_o | output | 1 | Convert-start, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| byte_sel_o | output | 1 | Selects the low byte on bus bits 15..8 in 8-bit mode |
| res_valid_o | output | 1 | Result word is valid |
| res_data_o | output | DATA_W | Assembled two's-complement result |
| err_o | output | 1 | One-cycle pulse when a busy edge does not arrive in time |

## Verification
A converter model runs next to two instances, one in 8-bit mode and one in 16-bit mode. It drives garbage on the bus until shortly after each read or byte-select change, and on the low bits it drives all ones in the folded phase. A bench that samples too early, reads the wrong pins or swaps the halves therefore gets a wrong word. The codes used are the positive and negative limits, minus one, zero and two asymmetric patterns, which separates half-swaps, sign handling and bit slips. A held result with start asserted shows whether back-pressure is honoured. A busy line that never rises and a busy line that sticks high exercise each timeout path, and a normal conversion afterwards shows recovery. Pulse widths, the quiet zones and byte-select spacing are measured cycle by cycle at the pins.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_GAP,
    ST_CONV_LO,
    ST_CONV_HI,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_POST_GAP,
    ST_RD1,
    ST_RD_GAP,
    ST_RD2
  } rd_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_busy_sync.sv
module adc_rd_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[STAGES-1];
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = prev_q & ~sh_q[STAGES-1];

  // R4: the falling-edge indication lasts a single cycle
  p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble #(
  parameter int DATA_W    = 16,
  parameter int BYTE_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] word_o
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] word_q;

  generate
    if (BYTE_MODE != 0) begin : g_fold
      logic unused_low_pins;
      assign unused_low_pins = ^bus_i[HALF-1:0];
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '0;
        end else begin
          if (cap_hi_i) word_q[DATA_W-1:HALF] <= bus_i[DATA_W-1:HALF];
          if (cap_lo_i) word_q[HALF-1:0]      <= bus_i[DATA_W-1:HALF];
        end
      end
    end else begin : g_full
      logic unused_cap_lo;
      assign unused_cap_lo = cap_lo_i;
      always_ff @(posedge clk) begin
        if (rst)           word_q <= '0;
        else if (cap_hi_i) word_q <= bus_i;
      end
      // R5: single-read mode never asks for a second capture
      p_no_second_cap_r5: assert property (@(posedge clk) disable iff (rst)
        !cap_lo_i);
    end
  endgenerate

  assign word_o = word_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int BYTE_MODE      = 1,
  parameter int SYNC_STAGES    = 2,
  parameter int CONV_LOW_CYC   = 5,
  parameter int CONV_HIGH_CYC  = 5,
  parameter int QUIET_PRE_CYC  = 13,
  parameter int QUIET_POST_CYC = 10,
  parameter int RD_LOW_CYC     = 13,
  parameter int RD_HIGH_CYC    = 5,
  parameter int BYTE_GAP_CYC   = 13,
  parameter int TIMEOUT_CYC    = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              res_ready_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              convst_n_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              byte_sel_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              err_o
);

  // gap between the two reads, stretched so byte-select edges keep their spacing
  localparam int GAP_CYC = (RD_HIGH_CYC + RD_LOW_CYC >= BYTE_GAP_CYC) ?
                           RD_HIGH_CYC : (BYTE_GAP_CYC - RD_LOW_CYC);
  localparam int MAX_DUR = max2(max2(max2(CONV_LOW_CYC, CONV_HIGH_CYC),
                                     max2(RD_LOW_CYC, GAP_CYC)), TIMEOUT_CYC);
  localparam int TW      = $clog2(MAX_DUR + 1) + 1;
  localparam int QMAX    = max2(QUIET_PRE_CYC, QUIET_POST_CYC);
  localparam int GW      = $clog2(QMAX + 1) + 1;
  localparam logic [GW-1:0] PRE_SAT  = GW'(QUIET_PRE_CYC);
  localparam logic [GW-1:0] POST_SAT = GW'(QUIET_POST_CYC);

  rd_state_e state_q, state_d;

  logic          t_load, t_done;
  logic [TW-1:0] t_val;
  logic          busy_lvl, busy_fall;
  logic          cap_hi, cap_lo, finish, tmo;
  logic [GW-1:0] rd_gap_q, cv_gap_q;
  logic          convst_n_q, cs_n_q, rd_n_q, byte_q, valid_q, err_q;
  logic [DATA_W-1:0] word;

  function automatic logic [TW-1:0] hold_len(input rd_state_e s);
    case (s)
      ST_CONV_LO:        hold_len = TW'(CONV_LOW_CYC - 1);
      ST_CONV_HI:        hold_len = TW'(CONV_HIGH_CYC - 1);
      ST_WAIT_HI,
      ST_WAIT_LO:        hold_len = TW'(TIMEOUT_CYC - 1);
      ST_RD1, ST_RD2:    hold_len = TW'(RD_LOW_CYC - 1);
      ST_RD_GAP:         hold_len = TW'(GAP_CYC - 1);
      default:           hold_len = '0;
    endcase
  endfunction

  adc_rd_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (busy_i),
    .level_o (busy_lvl),
    .fall_o  (busy_fall)
  );

  adc_rd_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  adc_rd_assemble #(.DATA_W(DATA_W), .BYTE_MODE(BYTE_MODE)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .cap_hi_i (cap_hi),
    .cap_lo_i (cap_lo),
    .bus_i    (bus_i),
    .word_o   (word)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    tmo     = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE:     if (start_i && !valid_q) state_d = ST_PRE_GAP;
      ST_PRE_GAP:  if (rd_gap_q >= PRE_SAT) state_d = ST_CONV_LO;
      ST_CONV_LO:  if (t_done) state_d = ST_CONV_HI;
      ST_CONV_HI:  if (t_done) state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (busy_lvl) begin
          state_d = ST_WAIT_LO;
        end else if (t_done) begin
          state_d = ST_IDLE;
          tmo     = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (busy_fall) begin
          state_d = ST_POST_GAP;
        end else if (t_done) begin
          state_d = ST_IDLE;
          tmo     = 1'b1;
        end
      end
      ST_POST_GAP: if (cv_gap_q >= POST_SAT) state_d = ST_RD1;
      ST_RD1: begin
        if (t_done) begin
          if (BYTE_MODE != 0) begin
            state_d = ST_RD_GAP;
          end else begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end
      end
      ST_RD_GAP:   if (t_done) state_d = ST_RD2;
      ST_RD2: begin
        if (t_done) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  assign t_load = (state_d != state_q);
  assign t_val  = hold_len(state_d);
  // capture on the last cycle of each read-low window
  assign cap_hi = (state_q == ST_RD1) && t_done;
  assign cap_lo = (state_q == ST_RD2) && t_done;

  // state and registered pin outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      convst_n_q <= 1'b1;
      cs_n_q     <= 1'b1;
      rd_n_q     <= 1'b1;
      byte_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      convst_n_q <= (state_d != ST_CONV_LO);
      cs_n_q     <= (state_d == ST_IDLE);
      rd_n_q     <= !((state_d == ST_RD1) || (state_d == ST_RD2));
      byte_q     <= (state_d == ST_RD_GAP) || (state_d == ST_RD2);
      err_q      <= tmo;
    end
  end

  // result handshake
  always_ff @(posedge clk) begin
    if (rst)              valid_q <= 1'b0;
    else if (finish)      valid_q <= 1'b1;
    else if (res_ready_i) valid_q <= 1'b0;
  end

  // cycles since the last read ended, saturating
  always_ff @(posedge clk) begin
    if (rst)                   rd_gap_q <= PRE_SAT;
    else if (!rd_n_q)          rd_gap_q <= '0;
    else if (rd_gap_q < PRE_SAT) rd_gap_q <= rd_gap_q + 1'b1;
  end

  // cycles since the convert-start falling edge, saturating
  always_ff @(posedge clk) begin
    if (rst)                                              cv_gap_q <= POST_SAT;
    else if (state_d == ST_CONV_LO && state_q != ST_CONV_LO) cv_gap_q <= '0;
    else if (cv_gap_q < POST_SAT)                         cv_gap_q <= cv_gap_q + 1'b1;
  end

  assign convst_n_o  = convst_n_q;
  assign cs_n_o      = cs_n_q;
  assign rd_n_o      = rd_n_q;
  assign byte_sel_o  = byte_q;
  assign res_valid_o = valid_q;
  assign res_data_o  = word;
  assign err_o       = err_q;

  // R2: chip select already low in the cycle before convert-start falls
  p_cs_setup_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(convst_n_q) |-> $past(!cs_n_q));

  // R3: quiet time after the last read before a convert-start edge
  p_pre_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(convst_n_q) |-> (rd_gap_q >= PRE_SAT));

  // R4: no read inside the window after the convert-start edge
  p_post_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_n_q |-> (cv_gap_q >= POST_SAT));

  // R11: strobes only while selected
  p_cs_cover_r11: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_q || !convst_n_q) |-> !cs_n_q);

  // R8: pending result blocks conversion and stays put
  p_no_conv_pending_r8: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> convst_n_q);
  p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !res_ready_i) |=> (valid_q && $stable(word)));

  // R9: error is a single-cycle pulse
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

  generate
    if (BYTE_MODE == 0) begin : g_chk16
      // R5: byte select unused in single-read mode
      p_byte_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !byte_q);
    end else begin : g_chk8
      // R6: byte select only moves while the read strobe is high
      p_byte_rd_high_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(byte_q) || $fell(byte_q)) |-> rd_n_q);
    end
  endgenerate

endmodule

// File: tb/adc_rd_ctrl_tb.sv
module adc_conv_model #(
  parameter int CONV_LOW  = 5,
  parameter int CONV_HIGH = 5,
  parameter int PRE       = 13,
  parameter int POST      = 10,
  parameter int RD_LOW    = 13,
  parameter int RD_HIGH   = 5,
  parameter int BYTE_GAP  = 13,
  parameter int CONV_T    = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        convst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        byte_sel,
  input  logic [15:0] code_i,
  input  logic        no_rise_i,
  input  logic        stuck_i,
  output logic        busy_o,
  output logic [15:0] bus_o,
  output int          v_conv,
  output int          v_pre,
  output int          v_post,
  output int          v_rdw,
  output int          v_rdh,
  output int          v_byte,
  output int          v_cs,
  output int          n_conv
);
  logic        cv_p, rd_p, by_p, conv_on, seen_fall;
  logic [15:0] pend, word;
  int cnt, cv_lo, rd_lo, s_rd, s_cv, s_cv_rise, s_by, vdly;

  always @(negedge clk) begin
    if (rst) begin
      cv_p <= 1'b1; rd_p <= 1'b1; by_p <= 1'b0; conv_on <= 1'b0; seen_fall <= 1'b0;
      busy_o <= 1'b0; bus_o <= 16'hA5A5; word <= 16'h0; pend <= 16'h0;
      cnt <= 0; cv_lo <= 0; rd_lo <= 0; s_rd <= 10000; s_cv <= 10000;
      s_cv_rise <= 10000; s_by <= 10000; vdly <= 0;
      v_conv <= 0; v_pre <= 0; v_post <= 0; v_rdw <= 0; v_rdh <= 0;
      v_byte <= 0; v_cs <= 0; n_conv <= 0;
    end else begin
      cv_p <= convst_n; rd_p <= rd_n; by_p <= byte_sel;
      // convert-start edges
      if (!convst_n && cv_p) begin
        if (s_rd < PRE) v_pre <= v_pre + 1;
        if (s_cv_rise < CONV_HIGH) v_conv <= v_conv + 1;
        if (cs_n) v_cs <= v_cs + 1;
        s_cv <= 1; cv_lo <= 1; n_conv <= n_conv + 1;
        conv_on <= !cs_n; cnt <= 0; pend <= code_i; seen_fall <= 1'b0;
      end else begin
        if (s_cv < 10000) s_cv <= s_cv + 1;
        if (!convst_n) cv_lo <= cv_lo + 1;
      end
      if (convst_n && !cv_p) begin
        if (cv_lo != CONV_LOW) v_conv <= v_conv + 1;
        s_cv_rise <= 1;
      end else if (s_cv_rise < 10000) s_cv_rise <= s_cv_rise + 1;
      // conversion and busy
      if (conv_on) begin
        cnt <= cnt + 1;
        if (cnt == 2 && !no_rise_i) busy_o <= 1'b1;
        if (cnt == 2 + CONV_T) begin
          conv_on <= 1'b0;
          word    <= pend;
          if (!stuck_i) begin busy_o <= 1'b0; seen_fall <= 1'b1; end
        end
      end else if (busy_o && !stuck_i) begin
        busy_o <= 1'b0;
      end
      // read strobe edges
      if (!rd_n && rd_p) begin
        if (s_cv < POST || busy_o || !seen_fall) v_post <= v_post + 1;
        if (s_rd < RD_HIGH) v_rdh <= v_rdh + 1;
        if (cs_n) v_cs <= v_cs + 1;
        rd_lo <= 1;
      end else if (!rd_n) rd_lo <= rd_lo + 1;
      if (rd_n && !rd_p) begin
        if (rd_lo != RD_LOW) v_rdw <= v_rdw + 1;
        s_rd <= 1;
      end else if (s_rd < 10000) s_rd <= s_rd + 1;
      // byte select spacing
      if (byte_sel != by_p) begin
        if (s_by < BYTE_GAP) v_byte <= v_byte + 1;
        s_by <= 1;
      end else if (s_by < 10000) s_by <= s_by + 1;
      // data bus with a short settling time
      if ((!rd_n && rd_p) || (byte_sel != by_p)) vdly <= 0;
      else if (vdly < 100) vdly <= vdly + 1;
      if (!cs_n && !rd_n && !(!rd_n && rd_p) && (byte_sel == by_p) && vdly >= 2)
        bus_o <= byte_sel ? {word[7:0], 8'hFF} : word;
      else
        bus_o <= 16'hA5A5;
    end
  end
endmodule

module adc_rd_ctrl_tb;
  localparam int CONV_LOW = 5, CONV_HIGH = 5, PRE = 13, POST = 10;
  localparam int RD_LOW = 13, RD_HIGH = 5, BYTE_GAP = 13, TMO = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start_s [2];
  logic        ready_s [2];
  logic        no_rise [2];
  logic        stuck   [2];
  logic [15:0] code_s  [2];
  logic        busy_w  [2];
  logic [15:0] bus_w   [2];
  logic        convst_w[2];
  logic        cs_w    [2];
  logic        rd_w    [2];
  logic        byte_w  [2];
  logic        valid_w [2];
  logic [15:0] data_w  [2];
  logic        err_w   [2];
  int v_conv[2], v_pre[2], v_post[2], v_rdw[2], v_rdh[2], v_byte[2], v_cs[2], n_conv[2];

  int checks = 0;
  int failures = 0;

  adc_rd_ctrl #(.BYTE_MODE(1), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_s[0]), .res_ready_i(ready_s[0]),
    .busy_i(busy_w[0]), .bus_i(bus_w[0]), .convst_n_o(convst_w[0]),
    .cs_n_o(cs_w[0]), .rd_n_o(rd_w[0]), .byte_sel_o(byte_w[0]),
    .res_valid_o(valid_w[0]), .res_data_o(data_w[0]), .err_o(err_w[0]));

  adc_rd_ctrl #(.BYTE_MODE(0), .TIMEOUT_CYC(TMO)) u_dut16 (
    .clk(clk), .rst(rst), .start_i(start_s[1]), .res_ready_i(ready_s[1]),
    .busy_i(busy_w[1]), .bus_i(bus_w[1]), .convst_n_o(convst_w[1]),
    .cs_n_o(cs_w[1]), .rd_n_o(rd_w[1]), .byte_sel_o(byte_w[1]),
    .res_valid_o(valid_w[1]), .res_data_o(data_w[1]), .err_o(err_w[1]));

  for (genvar g = 0; g < 2; g++) begin : g_model
    adc_conv_model #(.CONV_LOW(CONV_LOW), .CONV_HIGH(CONV_HIGH), .PRE(PRE),
      .POST(POST), .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH), .BYTE_GAP(BYTE_GAP)) u_model (
      .clk(clk), .rst(rst), .convst_n(convst_w[g]), .cs_n(cs_w[g]), .rd_n(rd_w[g]),
      .byte_sel(byte_w[g]), .code_i(code_s[g]), .no_rise_i(no_rise[g]),
      .stuck_i(stuck[g]), .busy_o(busy_w[g]), .bus_o(bus_w[g]),
      .v_conv(v_conv[g]), .v_pre(v_pre[g]), .v_post(v_post[g]), .v_rdw(v_rdw[g]),
      .v_rdh(v_rdh[g]), .v_byte(v_byte[g]), .v_cs(v_cs[g]), .n_conv(n_conv[g]));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_end(input int d, output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (valid_w[d] || err_w[d]) got = 1'b1;
    end
  endtask

  task automatic pulse_start(input int d);
    start_s[d] = 1'b1;
    @(negedge clk);
    start_s[d] = 1'b0;
  endtask

  task automatic accept(input int d, input string req);
    ready_s[d] = 1'b1;
    @(negedge clk);
    ready_s[d] = 1'b0;
    chk(req, {31'd0, valid_w[d]}, 32'd0);
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      chk("R1 convst", {31'd0, convst_w[d]}, 32'd1);
      chk("R1 cs", {31'd0, cs_w[d]}, 32'd1);
      chk("R1 rd", {31'd0, rd_w[d]}, 32'd1);
      chk("R1 byte", {31'd0, byte_w[d]}, 32'd0);
      chk("R1 valid", {31'd0, valid_w[d]}, 32'd0);
      chk("R1 err", {31'd0, err_w[d]}, 32'd0);
      chk("R1 data", {16'd0, data_w[d]}, 32'd0);
    end
  endtask

  task automatic t_conv(input int d, input logic [15:0] code, input string req);
    bit got;
    code_s[d] = code;
    pulse_start(d);
    wait_end(d, got);
    chk(req, {31'd0, got & valid_w[d] & ~err_w[d]}, 32'd1);
    chk(req, {16'd0, data_w[d]}, {16'd0, code});
    accept(d, "R8 clear");
  endtask

  task automatic t_hold();
    bit got;
    int conv0, bad;
    logic [15:0] held;
    code_s[0] = 16'h3C96;
    pulse_start(0);
    wait_end(0, got);
    held  = data_w[0];
    conv0 = n_conv[0];
    bad   = 0;
    start_s[0] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!convst_w[0] || !valid_w[0] || data_w[0] !== held) bad++;
    end
    start_s[0] = 1'b0;
    chk("R8 held and no convert", bad, 0);
    chk("R8 no new conversion", n_conv[0], conv0);
    chk("R8 value", {16'd0, held}, 32'h3C96);
    accept(0, "R8 clear");
  endtask

  task automatic t_timeout(input bit fall_case, input string req);
    bit got;
    int wid;
    if (fall_case) stuck[0] = 1'b1; else no_rise[0] = 1'b1;
    pulse_start(0);
    wait_end(0, got);
    chk(req, {31'd0, got & err_w[0]}, 32'd1);
    wid = 0;
    for (int i = 0; i < 5; i++) begin
      if (err_w[0]) wid++;
      @(negedge clk);
    end
    chk(req, wid, 1);
    chk(req, {31'd0, valid_w[0]}, 32'd0);
    chk(req, {31'd0, cs_w[0]}, 32'd1);
    stuck[0] = 1'b0;
    no_rise[0] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      start_s[d] = 1'b0; ready_s[d] = 1'b0; no_rise[d] = 1'b0;
      stuck[d] = 1'b0; code_s[d] = 16'h0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // 8-bit fold-back path
    t_conv(0, 16'h7FFF, "R6 R7 positive limit");
    t_conv(0, 16'h8000, "R6 R7 negative limit");
    t_conv(0, 16'hFFFF, "R7 minus one");
    t_conv(0, 16'h0000, "R7 zero");
    t_conv(0, 16'h12C4, "R6 half order");
    // 16-bit single read
    t_conv(1, 16'hA55A, "R5 full word");
    t_conv(1, 16'h8001, "R5 R7 sign");
    t_hold();
    t_timeout(1'b0, "R9 busy never rises");
    t_timeout(1'b1, "R10 busy stuck high");
    t_conv(0, 16'h5E21, "R10 recovery");
    for (int d = 0; d < 2; d++) begin
      chk("R2 convert widths", v_conv[d], 0);
      chk("R3 quiet before convert", v_pre[d], 0);
      chk("R4 read after busy and quiet", v_post[d], 0);
      chk("R5 read low width", v_rdw[d], 0);
      chk("R6 read high gap", v_rdh[d], 0);
      chk("R6 byte spacing", v_byte[d], 0);
      chk("R11 chip select cover", v_cs[d], 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule